// File: doc/BRIEF.md
# Two-Scale Fixed-Point Adder/Subtractor

This block adds or subtracts two words in a fixed-point format that has two scalings. Each word has a single scale-select bit in its top position and a two's-complement significand below it. A clear select bit gives a fine scaling with `FINE` fractional bits. A set select bit gives a coarse scaling with `COARSE` fractional bits, and `FINE` must be greater than `COARSE`. The result is the exact sum or difference, returned in the same format.

Both operands are expanded to one internal signed value that carries `FINE` fractional bits, so coarse operands are shifted left by `FINE-COARSE`. The internal adder is one bit wider than these values, so its result is exact. The result is compared against a fixed boundary magnitude `B = 2^(W-FINE-2)` to pick its scaling. In-range results keep the fine scaling unchanged. Larger results are shifted right and rounded toward negative infinity into the coarse scaling. If a result does not fit the coarse significand either, it is clamped to the most positive or most negative coarse code.

The result is registered, giving one cycle of latency, and an output valid flag goes with it.

Top module: `dfx_addsub_unit`

## Requirements
- R1: With the top bit (bit W-1) of an operand clear, the operand's value is its 31-bit significand (bits W-2..0, two's complement) times 2^-FINE.
- R2: With the top bit of an operand set, the operand's value is its significand times 2^-COARSE. It is aligned to the fine scaling before the operation, with no loss.
- R3: With op_sub low the result is A+B. With op_sub high the result is A-B.
- R4: When the exact result D satisfies -B <= D < B, with B = 2^(W-FINE-2), the result word has bit W-1 clear and its significand is D·2^FINE exactly. The value -B itself stays fine.
- R5: When D < -B or D >= B, the result word has bit W-1 set and its significand is floor(D·2^COARSE), rounded toward negative infinity.
- R6: A coarse significand above 2^(W-2)-1 saturates to the word 0xBFFFFFFF at defaults. A coarse significand below -2^(W-2) saturates to the word 0xC0000000 at defaults.
- R7: out_valid equals in_valid from the previous clock. The result of an operation appears at the edge after in_valid was high.
- R8: While in_valid is low, result keeps its previous value whatever the operands and op_sub do.
- R9: When rst_n is low at a rising edge (synchronous, active low), out_valid and result are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and op_sub are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (A-B) |
| opnd_a | input | W | Operand A: scale bit and significand |
| opnd_b | input | W | Operand B: scale bit and significand |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | W | Registered result word |

## Verification
On every cycle, the assertions check the valid timing, that the result holds while idle, and the reset clearing. They also check that the scale bit of each result agrees with the internal range decision, and that a positive saturation event always produces the clamp code. Only the bench's scenarios can show the numeric side: the exact values at the fine and coarse edges of the boundary, the floor rounding of negative coarse results, the alignment of coarse operands, and both saturation codes. The bench compares these against values worked out by hand.

// File: rtl/dfx_addsub_pkg.sv
package dfx_addsub_pkg;
  typedef enum logic {
    SCALE_FINE   = 1'b0,
    SCALE_COARSE = 1'b1
  } scale_e;
endpackage

// File: rtl/dfx_unpack.sv
module dfx_unpack #(
  parameter int SIG   = 31,
  parameter int SHIFT = 12,
  localparam int OPW  = SIG + SHIFT
) (
  input  logic [SIG:0]            word,
  output logic signed [OPW-1:0]   val
);
  import dfx_addsub_pkg::*;

  // Expand to an internal value that carries the fine number of fraction bits.
  function automatic logic signed [OPW-1:0] decode(input logic [SIG:0] w);
    logic [SIG-1:0] sig;
    sig = w[SIG-1:0];
    if (scale_e'(w[SIG]) == SCALE_COARSE)
      return {sig, {SHIFT{1'b0}}};
    else
      return {{SHIFT{sig[SIG-1]}}, sig};
  endfunction

  assign val = decode(word);
endmodule

// File: rtl/dfx_sum.sv
module dfx_sum #(
  parameter int OPW = 43,
  localparam int IW = OPW + 1
) (
  input  logic signed [OPW-1:0] a,
  input  logic signed [OPW-1:0] b,
  input  logic                  sub,
  output logic signed [IW-1:0]  sum
);
  // One guard bit: the sum or difference of two OPW-bit values always fits.
  function automatic logic signed [IW-1:0] addsub(input logic signed [OPW-1:0] x,
                                                  input logic signed [OPW-1:0] y,
                                                  input logic s);
    logic signed [IW-1:0] xe, ye;
    xe = {x[OPW-1], x};
    ye = {y[OPW-1], y};
    return s ? (xe - ye) : (xe + ye);
  endfunction

  assign sum = addsub(a, b, sub);
endmodule

// File: rtl/dfx_pack.sv
module dfx_pack #(
  parameter int SIG   = 31,
  parameter int SHIFT = 12,
  localparam int IW   = SIG + SHIFT + 1,
  localparam int QW   = IW - SHIFT
) (
  input  logic signed [IW-1:0] sum,
  output logic [SIG:0]         word,
  output logic                 coarse_sel,
  output logic                 sat_hi,
  output logic                 sat_lo
);
  import dfx_addsub_pkg::*;

  localparam logic [SIG-1:0] SIG_MAX = {1'b0, {(SIG-1){1'b1}}};
  localparam logic [SIG-1:0] SIG_MIN = {1'b1, {(SIG-1){1'b0}}};

  logic [IW-SIG:0]     upper;
  logic signed [IW-1:0] shifted;
  logic [QW-1:0]       q;

  // Fits the fine range [-2^(SIG-1), 2^(SIG-1)) iff all bits from SIG-1 up agree.
  assign upper      = sum[IW-1:SIG-1];
  assign coarse_sel = !((&upper) || !(|upper));

  // Arithmetic shift floors toward negative infinity.
  assign shifted = sum >>> SHIFT;
  assign q       = shifted[QW-1:0];

  assign sat_hi = coarse_sel && !q[QW-1] &&  q[QW-2];
  assign sat_lo = coarse_sel &&  q[QW-1] && !q[QW-2];

  always_comb begin
    if (!coarse_sel)
      word = {SCALE_FINE, sum[SIG-1:0]};
    else if (sat_hi)
      word = {SCALE_COARSE, SIG_MAX};
    else if (sat_lo)
      word = {SCALE_COARSE, SIG_MIN};
    else
      word = {SCALE_COARSE, q[SIG-1:0]};
  end
endmodule

// File: rtl/dfx_addsub_unit.sv
module dfx_addsub_unit #(
  parameter int W      = 32,
  parameter int FINE   = 16,
  parameter int COARSE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         op_sub,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int SIG   = W - 1;
  localparam int SHIFT = FINE - COARSE;
  localparam int OPW   = SIG + SHIFT;
  localparam int IW    = OPW + 1;

  logic signed [OPW-1:0] val_a, val_b;
  logic signed [IW-1:0]  sum_int;
  logic [W-1:0]          packed_word;
  logic                  coarse_sel, sat_hi, sat_lo;

  dfx_unpack #(.SIG(SIG), .SHIFT(SHIFT)) u_unpack_a (.word(opnd_a), .val(val_a));
  dfx_unpack #(.SIG(SIG), .SHIFT(SHIFT)) u_unpack_b (.word(opnd_b), .val(val_b));

  dfx_sum #(.OPW(OPW)) u_sum (.a(val_a), .b(val_b), .sub(op_sub), .sum(sum_int));

  dfx_pack #(.SIG(SIG), .SHIFT(SHIFT)) u_pack (
    .sum(sum_int), .word(packed_word),
    .coarse_sel(coarse_sel), .sat_hi(sat_hi), .sat_lo(sat_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= packed_word;
    end
  end
endmodule

// File: rtl/dfx_addsub_unit_chk.sv
module dfx_addsub_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         coarse_sel,
  input logic         sat_hi,
  input logic         sat_lo
);
  localparam logic [W-1:0] CLAMP_HI = {1'b1, 1'b0, {(W-2){1'b1}}};

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r9_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0));
  a_r4_fine_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !coarse_sel) |=> !result[W-1]);
  a_r5_coarse_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && coarse_sel) |=> result[W-1]);
  a_r6_sat_only_coarse: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hi || sat_lo) |-> coarse_sel);
  a_r6_sat_hi_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_hi) |=> result == CLAMP_HI);
endmodule

bind dfx_addsub_unit dfx_addsub_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .result(result), .coarse_sel(coarse_sel), .sat_hi(sat_hi), .sat_lo(sat_lo)
);

// File: tb/dfx_addsub_unit_test.sv
module dfx_addsub_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  dfx_addsub_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
  );

  // {a, b, sub, expected}; defaults W=32, FINE=16, COARSE=4
  localparam int NV = 14;
  localparam logic [96:0] VEC [0:NV-1] = '{
    {32'h00000005, 32'h00000003, 1'b0, 32'h00000008}, // R1 R3 add
    {32'h00000005, 32'h00000003, 1'b1, 32'h00000002}, // R3 sub
    {32'h00000003, 32'h00000005, 1'b1, 32'h7FFFFFFE}, // R3 negative fine
    {32'h80000001, 32'h00000001, 1'b0, 32'h00001001}, // R2 coarse aligned
    {32'h3FFFFFFF, 32'h00000001, 1'b0, 32'h80040000}, // R5 reaches +B
    {32'h3FFFFFFF, 32'h00000000, 1'b0, 32'h3FFFFFFF}, // R4 just under B
    {32'h40000000, 32'h00000000, 1'b0, 32'h40000000}, // R4 -B stays fine
    {32'h40000000, 32'h00000001, 1'b1, 32'hFFFBFFFF}, // R5 below -B, floor
    {32'hBFFFFFFF, 32'h80000001, 1'b0, 32'hBFFFFFFF}, // R6 clamp high
    {32'hC0000000, 32'h80000001, 1'b1, 32'hC0000000}, // R6 clamp low
    {32'h80000010, 32'h80000020, 1'b0, 32'h00030000}, // R2 R4 coarse in, fine out
    {32'h80100000, 32'h00000FFF, 1'b0, 32'h80100000}, // R5 truncation positive
    {32'hFFF00000, 32'h00000001, 1'b1, 32'hFFEFFFFF}, // R5 floor negative
    {32'h00000000, 32'h40000000, 1'b1, 32'h80040000}  // R3 R5 minus most negative
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset valid", {31'b0, out_valid}, 32'h0);
    check("R9 reset result", result, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      opnd_a   = VEC[i][96:65];
      opnd_b   = VEC[i][64:33];
      op_sub   = VEC[i][32];
      in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R7 valid vec%0d", i), {31'b0, out_valid}, 32'h1);
      check($sformatf("R1-R6 vec%0d", i), result, VEC[i][31:0]);
    end

    // R8: idle cycles with new operands must not touch result
    held     = result;
    in_valid = 1'b0;
    opnd_a   = 32'h00001234;
    opnd_b   = 32'h80000777;
    op_sub   = 1'b1;
    @(negedge clk);
    check("R7 valid low", {31'b0, out_valid}, 32'h0);
    check("R8 hold", result, held);
    op_sub = 1'b0;
    opnd_a = 32'h3FFFFFFF;
    @(negedge clk);
    check("R8 hold again", result, held);

    // R7 back-to-back then single gap
    in_valid = 1'b1;
    opnd_a = 32'h00000010; opnd_b = 32'h00000020; op_sub = 1'b0;
    @(negedge clk);
    check("R7 first", result, 32'h00000030);
    opnd_a = 32'h00000010; opnd_b = 32'h00000020; op_sub = 1'b1;
    @(negedge clk);
    check("R7 second", result, 32'h7FFFFFF0);
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 gap valid", {31'b0, out_valid}, 32'h0);

    // R9 mid-run reset
    in_valid = 1'b1;
    rst_n    = 1'b0;
    @(negedge clk);
    check("R9 mid reset valid", {31'b0, out_valid}, 32'h0);
    check("R9 mid reset result", result, 32'h0);
    rst_n    = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    finish_run();
  end
endmodule